// File: doc/BRIEF.md
# Switch Register Serial Access Master

This block is a hardware master for a two-wire serial management link to a managed Ethernet switch. Each request is a single read or write of one internal switch register. The request carries a direction flag, a 10-bit register address, a data-length select and write data, and it arrives on a valid/ready handshake. The master generates the serial clock, an active-low chip select and a bidirectional data line. The data line is split into an output value, an output enable and an input. When the frame ends, the master pulses a done strobe, and for reads it returns the data it captured.

A frame has the following parts, in order:

1. A chip-select pulse.
2. A run of 32 ones.
3. A two-bit start pattern and a two-bit opcode.
4. The 10-bit address.
5. Two turnaround bits, which the master drives high.
6. A data field of 16 or 32 bits. For a read the master releases the line after one extra low phase; for a write it keeps driving.
7. A trailer of four dummy clocks with the line low. The chip select then rises.

Every clock phase lasts `HALF_CYCLES` system clock cycles. That makes the link rate a parameter of the system clock.

Top module: `swRegMaster`

## Requirements
- R1: After reset the master is idle: chip select (`smCsN`) high, serial clock low, `reqReady` high. A request is accepted in a cycle where `reqValid` and `reqReady` are both high.
- R2: A frame starts with chip select high for at least `HALF_CYCLES` cycles. Chip select then falls while the serial clock is low, and the clock stays low for exactly `2*HALF_CYCLES` cycles before its first rising edge. The serial clock only pulses while chip select is low.
- R3: The first 46 bits seen at the rising clock edges, with the master driving, are: 32 ones, then start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then address bits 9 down to 0, most significant first.
- R4: Each serial clock high phase lasts `HALF_CYCLES` cycles. Each low phase between pulses lasts `HALF_CYCLES` cycles, except before the first read data bit, where it lasts `2*HALF_CYCLES`. The data value and the output enable do not change while the clock is high.
- R5: Bits 47 and 48 of the frame are turnaround bits, which the master drives to 1 with its output enable high.
- R6: For a read, the output enable is low for all data bits. The data bits number 32 when `reqWide`=1 and 16 when `reqWide`=0. The master samples each bit on the cycle before the clock rises, most significant bit first. `rspData` then holds the word, zero-extended in the 16-bit case.
- R7: For a write, the master drives the data bits most significant first with its output enable high. It sends all 32 bits of `reqWdata` when `reqWide`=1, and only bits 15..0 when `reqWide`=0.
- R8: After the data field, the master drives the line low with its output enable high for exactly 4 clock pulses. Chip select then rises in the same cycle as the one-cycle `rspDone` pulse. The total number of rising edges in the frame is 48 + data length + 4.
- R9: `reqReady` stays low from acceptance until `rspDone`, so a request held valid during a frame is not taken. `rspDone` lasts one cycle and is followed by `reqReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Master idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 10 | Register address |
| reqWide | input | 1 | 1 = 32-bit data field, 0 = 16-bit |
| reqWdata | input | 32 | Write data |
| rspDone | output | 1 | One-cycle end-of-frame strobe |
| rspData | output | 32 | Read data, valid at `rspDone` |
| smClk | output | 1 | Serial clock |
| smCsN | output | 1 | Active-low chip select |
| smDout | output | 1 | Serial data output value |
| smDoe | output | 1 | Serial data output enable |
| smDin | input | 1 | Serial data line as seen at the pin |

## Verification
The bench targets the places where the frame changes character.

- **Turnaround bits.** A master that released the line during turnaround would let the bus-holder carry a stale value into bits 47 and 48.
- **Extra low phase before read data.** A master that dropped this phase, or added it to writes, would fail the low-phase length check on the 49th edge.
- **Data length select.** If the 16/32 choice were wrong, the rising-edge count per frame would be off, and a 16-bit write would send the upper half of the write word.
- **Acceptance while busy.** A request held valid through a busy frame must wait. Accepting it early would break the scoreboard order and the chip-select framing.
- **Read-data zero extension.** A 16-bit read must return with its upper bits zero.

// File: rtl/swRegPkg.sv
package swRegPkg;

  typedef enum logic [1:0] {
    D_ZERO,
    D_ONE,
    D_HDR,
    D_WR
  } doutSel_e;

  typedef struct packed {
    logic     load;
    logic     shiftHdr;
    logic     shiftWr;
    logic     sampleRd;
    doutSel_e doutSel;
  } dpCtl_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CSHI,
    S_CSLO,
    S_HLO,
    S_HHI,
    S_GAP,
    S_DLO,
    S_DHI,
    S_TLO,
    S_THI,
    S_FIN
  } state_e;

endpackage

// File: rtl/swRegCtrl.sv
module swRegCtrl
  import swRegPkg::*;
#(
  parameter int HALF_CYCLES = 5,
  parameter int HDR_LEN     = 48,
  parameter int DATA_W      = 32,
  parameter int NARROW_W    = 16,
  parameter int TRAIL_LEN   = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   curWrite,
  input  logic   curWide,
  output logic   reqReady,
  output logic   smClk,
  output logic   smCsN,
  output logic   smDoe,
  output logic   rspDone,
  output dpCtl_t dpCtl
);

  localparam int PH_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BIT_W = $clog2(HDR_LEN + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] HDR_LAST = BIT_W'(HDR_LEN - 1);
  localparam logic [BIT_W-1:0] WIDE_LAST = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] NARROW_LAST = BIT_W'(NARROW_W - 1);
  localparam logic [BIT_W-1:0] TRL_LAST = BIT_W'(TRAIL_LEN - 1);

  state_e state, stateNext;
  logic [PH_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic phaseEnd;
  logic dataLast;
  logic readData;

  assign phaseEnd = (phaseCnt == PH_LAST);
  assign dataLast = (bitCnt == (curWide ? WIDE_LAST : NARROW_LAST));

  always_comb begin
    stateNext = state;
    bitNext = bitCnt;
    case (state)
      S_IDLE: if (reqValid) stateNext = S_CSHI;
      S_CSHI: if (phaseEnd) stateNext = S_CSLO;
      S_CSLO: if (phaseEnd) begin
        stateNext = S_HLO;
        bitNext = '0;
      end
      S_HLO: if (phaseEnd) stateNext = S_HHI;
      S_HHI: if (phaseEnd) begin
        if (bitCnt == HDR_LAST) begin
          bitNext = '0;
          stateNext = curWrite ? S_DLO : S_GAP;
        end else begin
          bitNext = bitCnt + 1'b1;
          stateNext = S_HLO;
        end
      end
      S_GAP: if (phaseEnd) stateNext = S_DLO;
      S_DLO: if (phaseEnd) stateNext = S_DHI;
      S_DHI: if (phaseEnd) begin
        if (dataLast) begin
          bitNext = '0;
          stateNext = S_TLO;
        end else begin
          bitNext = bitCnt + 1'b1;
          stateNext = S_DLO;
        end
      end
      S_TLO: if (phaseEnd) stateNext = S_THI;
      S_THI: if (phaseEnd) begin
        if (bitCnt == TRL_LAST) begin
          stateNext = S_FIN;
        end else begin
          bitNext = bitCnt + 1'b1;
          stateNext = S_TLO;
        end
      end
      S_FIN: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phaseCnt <= '0;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      bitCnt <= bitNext;
      if (state == S_IDLE || state == S_FIN || phaseEnd) phaseCnt <= '0;
      else phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign readData = (state == S_DLO || state == S_DHI) && !curWrite;

  // pin decode straight from the state register
  assign reqReady = (state == S_IDLE);
  assign rspDone  = (state == S_FIN);
  assign smClk    = (state == S_HHI) || (state == S_DHI) || (state == S_THI);
  assign smCsN    = (state == S_IDLE) || (state == S_CSHI) || (state == S_FIN);
  assign smDoe    = !readData;

  always_comb begin
    dpCtl.load     = (state == S_IDLE) && reqValid;
    dpCtl.shiftHdr = (state == S_HHI) && phaseEnd;
    dpCtl.shiftWr  = (state == S_DHI) && phaseEnd && curWrite;
    dpCtl.sampleRd = (state == S_DLO) && phaseEnd && !curWrite;
    case (state)
      S_HLO, S_HHI: dpCtl.doutSel = D_HDR;
      S_GAP:        dpCtl.doutSel = D_ONE;
      S_DLO, S_DHI: dpCtl.doutSel = curWrite ? D_WR : D_ZERO;
      default:      dpCtl.doutSel = D_ZERO;
    endcase
  end

  assert_clk_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    smClk |-> !smCsN);

  assert_select_clk_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smCsN) |-> !smClk);

  assert_release_in_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    !smDoe |-> !smCsN);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> (!rspDone && reqReady));

endmodule

// File: rtl/swRegDatapath.sv
module swRegDatapath
  import swRegPkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PRE_LEN  = 32,
  parameter int HDR_LEN  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              smDin,
  output logic              smDout,
  output logic              curWrite,
  output logic              curWide,
  output logic [DATA_W-1:0] rspData
);

  localparam int PAD_W = DATA_W - NARROW_W;

  logic [HDR_LEN-1:0] hdrReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;
  logic [HDR_LEN-1:0] hdrInit;
  logic [DATA_W-1:0] wrInit;

  // preamble, start 01, opcode, address, turnaround driven high
  assign hdrInit = {{PRE_LEN{1'b1}}, 2'b01, (reqWrite ? 2'b01 : 2'b10), reqAddr, 2'b11};
  assign wrInit  = reqWide ? reqWdata : {reqWdata[NARROW_W-1:0], {PAD_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg <= '0;
      wrReg <= '0;
      rdReg <= '0;
      curWrite <= 1'b0;
      curWide <= 1'b0;
    end else if (dpCtl.load) begin
      hdrReg <= hdrInit;
      wrReg <= wrInit;
      rdReg <= '0;
      curWrite <= reqWrite;
      curWide <= reqWide;
    end else begin
      if (dpCtl.shiftHdr) hdrReg <= {hdrReg[HDR_LEN-2:0], 1'b0};
      if (dpCtl.shiftWr) wrReg <= {wrReg[DATA_W-2:0], 1'b0};
      if (dpCtl.sampleRd) rdReg <= {rdReg[DATA_W-2:0], smDin};
    end
  end

  always_comb begin
    case (dpCtl.doutSel)
      D_ONE:   smDout = 1'b1;
      D_HDR:   smDout = hdrReg[HDR_LEN-1];
      D_WR:    smDout = wrReg[DATA_W-1];
      default: smDout = 1'b0;
    endcase
  end

  assign rspData = curWide ? rdReg : {{PAD_W{1'b0}}, rdReg[NARROW_W-1:0]};

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.load |-> !(dpCtl.shiftHdr || dpCtl.shiftWr || dpCtl.sampleRd));

endmodule

// File: rtl/swRegMaster.sv
module swRegMaster
  import swRegPkg::*;
#(
  parameter int HALF_CYCLES = 5,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int NARROW_W    = 16,
  parameter int PRE_LEN     = 32,
  parameter int TRAIL_LEN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWide,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic              smClk,
  output logic              smCsN,
  output logic              smDout,
  output logic              smDoe,
  input  logic              smDin
);

  localparam int HDR_LEN = PRE_LEN + ADDR_W + 6;

  dpCtl_t dpCtl;
  logic curWrite;
  logic curWide;

  swRegCtrl #(
    .HALF_CYCLES(HALF_CYCLES),
    .HDR_LEN(HDR_LEN),
    .DATA_W(DATA_W),
    .NARROW_W(NARROW_W),
    .TRAIL_LEN(TRAIL_LEN)
  ) ctrl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .curWrite(curWrite),
    .curWide(curWide),
    .reqReady(reqReady),
    .smClk(smClk),
    .smCsN(smCsN),
    .smDoe(smDoe),
    .rspDone(rspDone),
    .dpCtl(dpCtl)
  );

  swRegDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NARROW_W(NARROW_W),
    .PRE_LEN(PRE_LEN),
    .HDR_LEN(HDR_LEN)
  ) dp (
    .clk(clk),
    .rstN(rstN),
    .dpCtl(dpCtl),
    .reqWrite(reqWrite),
    .reqWide(reqWide),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .smDin(smDin),
    .smDout(smDout),
    .curWrite(curWrite),
    .curWide(curWide),
    .rspData(rspData)
  );

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (smClk && $past(smClk)) |-> ($stable(smDout) && $stable(smDoe)));

endmodule

// File: tb/swRegMaster_test.sv
module swRegMaster_test;

  localparam int HALF = 5;
  localparam int HDR = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [9:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, rspDone, smClk, smCsN, smDout, smDoe;
  logic [31:0] rspData;
  logic slaveBit = 1'b0, heldVal = 1'b0, lineVal;

  // bus-holder line: master, else slave inside a frame, else last value
  assign lineVal = smDoe ? smDout : (!smCsN ? slaveBit : heldVal);
  always @(posedge clk) heldVal <= lineVal;

  swRegMaster uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWide(reqWide), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspData(rspData), .smClk(smClk), .smCsN(smCsN),
    .smDout(smDout), .smDoe(smDoe), .smDin(lineVal)
  );

  typedef struct {
    bit wr;
    bit [9:0] addr;
    bit wide;
    bit [31:0] wdata;
    bit [31:0] rword;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit capBit[0:127];
  bit capOe[0:127];
  int edgeCnt = 0, csHighCnt = 0, setupCnt = 0, hiCnt = 0, lowCnt = 0;
  bit inSetup = 0, prevClk = 0, prevCs = 1;

  always @(negedge clk) begin
    if (rstN) begin
      // falling serial clock
      if (!smClk && prevClk) begin
        chk(hiCnt == HALF, "R4 high phase length", hiCnt, HALF);
        lowCnt = 1;
        if (q.size() > 0 && edgeCnt >= HDR) begin
          automatic int n = q[0].wide ? 32 : 16;
          automatic int j = edgeCnt - HDR;
          if (j < n) slaveBit = q[0].rword[n-1-j];
        end
      end else if (!smClk) begin
        lowCnt++;
      end
      if (!smCsN) begin
        if (prevCs) begin
          chk(csHighCnt >= HALF, "R2 select high time", csHighCnt, HALF);
          chk(!smClk, "R2 clock low at select", smClk, 0);
          chk(!reqReady, "R9 not ready in frame", reqReady, 0);
          inSetup = 1;
          setupCnt = 0;
        end
        if (smClk && !prevClk) begin
          if (inSetup) begin
            chk(setupCnt == 2*HALF, "R2 setup low time", setupCnt, 2*HALF);
            inSetup = 0;
          end else if (q.size() > 0) begin
            automatic int expLow = (edgeCnt == HDR && !q[0].wr) ? 2*HALF : HALF;
            chk(lowCnt == expLow, "R4 low phase length", lowCnt, expLow);
          end
          if (edgeCnt < 128) begin
            capBit[edgeCnt] = lineVal;
            capOe[edgeCnt] = smDoe;
          end
          edgeCnt++;
          hiCnt = 1;
        end else if (smClk) begin
          hiCnt++;
        end else if (inSetup) begin
          setupCnt++;
        end
        csHighCnt = 0;
      end else begin
        csHighCnt++;
      end
      if (smClk && !prevClk && smCsN) chk(0, "R2 clock outside frame", 1, 0);
      if (rspDone) begin
        chk(smCsN, "R8 select high at done", smCsN, 1);
        if (q.size() == 0) begin
          chk(0, "R9 unexpected done", 1, 0);
        end else begin
          automatic item_t it = q.pop_front();
          automatic int n = it.wide ? 32 : 16;
          automatic logic [45:0] hdrExp = {32'hFFFF_FFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.addr};
          automatic logic [45:0] hdrAct = '0;
          automatic bit hdrOe = 1;
          automatic logic [31:0] datAct = '0, datExp;
          automatic bit datOeOk = 1;
          automatic logic [3:0] trlAct = '0;
          automatic bit trlOe = 1;
          automatic logic [31:0] rdExp;
          chk(edgeCnt == HDR + n + 4, "R8 rising edge count", edgeCnt, HDR + n + 4);
          for (int i = 0; i < 46; i++) begin
            hdrAct[45-i] = capBit[i];
            hdrOe &= capOe[i];
          end
          chk(hdrAct == hdrExp && hdrOe, "R3 header bits", hdrAct, hdrExp);
          chk(capBit[46] && capBit[47] && capOe[46] && capOe[47], "R5 turnaround driven high",
              {capOe[46], capOe[47], capBit[46], capBit[47]}, 4'hF);
          for (int j = 0; j < n; j++) begin
            datAct[n-1-j] = capBit[HDR+j];
            if (capOe[HDR+j] != it.wr) datOeOk = 0;
          end
          if (it.wr) begin
            datExp = it.wide ? it.wdata : {16'h0, it.wdata[15:0]};
            chk(datAct == datExp && datOeOk, "R7 write data bits", datAct, datExp);
          end else begin
            chk(datOeOk, "R6 line released for read data", datOeOk, 1);
            rdExp = it.wide ? it.rword : {16'h0, it.rword[15:0]};
            chk(rspData == rdExp, "R6 read data returned", rspData, rdExp);
          end
          for (int k = 0; k < 4; k++) begin
            trlAct[k] = capBit[HDR+n+k];
            trlOe &= capOe[HDR+n+k];
          end
          chk(trlAct == 4'h0 && trlOe, "R8 trailer driven low", {trlOe, trlAct}, 5'h10);
        end
        edgeCnt = 0;
      end
      prevClk = smClk;
      prevCs = smCsN;
    end
  end

  task automatic doXfer(input bit wr, input bit [9:0] addr, input bit wide,
                        input bit [31:0] wdata, input bit [31:0] rword);
    item_t it;
    it.wr = wr; it.addr = addr; it.wide = wide; it.wdata = wdata; it.rword = rword;
    q.push_back(it);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWide = wide; reqWdata = wdata;
    do @(posedge clk); while (!reqReady);
    #1 reqValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(smCsN && !smClk && reqReady, "R1 idle after reset", {smCsN, smClk, reqReady}, 3'b101);
    repeat (4) @(posedge clk);
    #1;
    // R6 narrow read, R7 narrow write drops upper half, back-to-back requests held (R9)
    doXfer(1'b0, 10'h013, 1'b0, 32'h0, 32'h0000_A5C3);
    doXfer(1'b0, 10'h2AA, 1'b1, 32'h0, 32'hDEAD_BEEF);
    doXfer(1'b1, 10'h155, 1'b0, 32'hFFFF_1234, 32'h0);
    doXfer(1'b1, 10'h3FF, 1'b1, 32'h8000_0001, 32'h0);
    doXfer(1'b0, 10'h000, 1'b0, 32'h0, 32'h0001_8001);
    doXfer(1'b0, 10'h200, 1'b1, 32'h0, 32'h0000_0000);
    while (q.size() > 0) @(posedge clk);
    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule